// File: doc/BRIEF.md
# Dual-Mode Current Acquisition Range Controller

This block is the digital side of one current-measurement channel that can work in two ways. At low currents the channel runs as a current-to-frequency converter. The block drives a branch-select bit that steers the input current into one of two integrator branches. The bit inverts each time either of two comparators trips. The number of inversions counted in a measurement window is the reading. At high currents the channel reads a fast ADC directly, and the block sums the samples that arrive during the window.

The block also chooses the range. A converter window whose count reaches a programmable full-scale value moves the channel to direct ADC mode. A direct window in which any sample falls below a programmable return threshold moves it back. Mode changes only happen at window boundaries. The window that follows a change is marked as not settled. Each window produces exactly one result, tagged with the mode in which it was taken.

Top module: `arc_range_ctrl`

## Requirements
- R1: While rst_ni is low and on the first cycle after it rises, branch_o is 0, direct_mode_o is 0 (converter mode) and res_valid_o is 0.
- R2: In converter mode, each rising edge on either bit of cmp_i inverts branch_o exactly once, however long the comparator stays high.
- R3: After branch_o inverts, comparator rising edges in the following holdoff_i cycles are ignored: they neither invert branch_o nor add to the count.
- R4: A window lasts period_i clock cycles (period_i >= 2). res_valid_o is a one-cycle pulse once per window. In converter mode res_value_o is the number of branch_o inversions in that window.
- R5: A converter window whose inversion count is >= max_count_i ends with direct_mode_o set to 1 (1 = direct ADC, 0 = converter). It is set on the same cycle that res_valid_o reports that window.
- R6: In direct mode, res_value_o is the sum of adc_data_i over the cycles of the window in which adc_valid_i is 1. Comparator edges do not change branch_o.
- R7: A direct window that contains at least one valid sample below return_thr_i ends with direct_mode_o cleared to 0.
- R8: direct_mode_o changes only at a window boundary. res_mode_o gives the mode that was active during the reported window.
- R9: res_ok_o is 0 for the first window after a mode change and 1 otherwise. The window right after reset reports 1.
- R10: Both the inversion count and the sample sum saturate at 2^24-1 and do not wrap.
- R11: In converter mode, ADC samples are ignored. They add nothing to res_value_o and cannot cause a mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 2 | Asynchronous comparator trip inputs |
| period_i | input | 16 | Window length in cycles |
| holdoff_i | input | 8 | Trip blanking cycles after an inversion |
| max_count_i | input | 24 | Full-scale inversion count |
| return_thr_i | input | 16 | ADC level below which converter mode is resumed |
| adc_valid_i | input | 1 | ADC sample strobe |
| adc_data_i | input | 16 | ADC sample |
| branch_o | output | 1 | Integrator branch select |
| direct_mode_o | output | 1 | Mode-switch control, 1 = direct ADC |
| res_valid_o | output | 1 | Result strobe, one per window |
| res_mode_o | output | 1 | Mode of the reported window |
| res_ok_o | output | 1 | Reported window was settled |
| res_value_o | output | 24 | Inversion count or sample sum |

## Verification
Some faults leave a wrong count or sum, or a lost blanking interval. These show up as a wrong res_value_o at the end of the window, within one window length. A wrong mode register shows up at once. direct_mode_o and res_mode_o disagree with the counts that were reported, and the settle flag is wrong in the window that follows. A branch bit that inverts in direct mode, or more than once per trip, can be seen on branch_o within three cycles of the comparator edge.

// File: rtl/arc_pkg.sv
package arc_pkg;
  typedef enum logic {
    MODE_CONV   = 1'b0,
    MODE_DIRECT = 1'b1
  } arc_mode_e;
endpackage

// File: rtl/arc_trip_detect.sv
module arc_trip_detect #(
  parameter int unsigned N_CMP = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CMP-1:0] cmp_i,
  output logic             trip_o
);
  logic [N_CMP-1:0] rise;

  for (genvar g = 0; g < N_CMP; g++) begin : g_ch
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= cmp_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign rise[g] = s2_q & ~s3_q;

    // R2: a rising edge is reported for one cycle only
    p_single_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise[g] |=> !rise[g]);
  end

  assign trip_o = |rise;
endmodule

// File: rtl/arc_toggle_counter.sv
module arc_toggle_counter #(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned HOLD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trip_i,
  input  logic              enable_i,
  input  logic [HOLD_W-1:0] holdoff_i,
  input  logic              clear_i,
  output logic              branch_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic              branch_q;
  logic [HOLD_W-1:0] hold_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic              tog;

  assign tog = trip_i & enable_i & (hold_q == '0);

  always_comb begin
    cnt_nxt = cnt_q;
    if (tog && cnt_q != CNT_MAX) cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      branch_q <= 1'b0;
      hold_q   <= '0;
      cnt_q    <= '0;
    end else begin
      branch_q <= branch_q ^ tog;
      if (tog)               hold_q <= holdoff_i;
      else if (hold_q != '0) hold_q <= hold_q - 1'b1;
      cnt_q <= clear_i ? '0 : cnt_nxt;
    end
  end

  assign branch_o = branch_q;
  assign count_o  = cnt_nxt;

  // R3: no inversion while blanking is active
  p_holdoff_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q != '0) |=> (branch_q == $past(branch_q)));
  // R6: branch frozen outside converter mode
  p_branch_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (branch_q == $past(branch_q)));
  // R10: count never wraps inside a window
  p_cnt_no_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/arc_direct_accum.sv
module arc_direct_accum #(
  parameter int unsigned ADC_W = 16,
  parameter int unsigned SUM_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             clear_i,
  input  logic             valid_i,
  input  logic [ADC_W-1:0] data_i,
  input  logic [ADC_W-1:0] thr_i,
  output logic [SUM_W-1:0] sum_o,
  output logic             low_o
);
  localparam int unsigned EXT_W = SUM_W + 1;

  logic [SUM_W-1:0] sum_q, sum_nxt;
  logic             low_q, low_nxt;
  logic [EXT_W-1:0] ext;
  logic             take;

  assign take = enable_i & valid_i;
  assign ext  = {1'b0, sum_q} + EXT_W'(data_i);

  always_comb begin
    sum_nxt = sum_q;
    if (take) sum_nxt = ext[SUM_W] ? {SUM_W{1'b1}} : ext[SUM_W-1:0];
    low_nxt = low_q | (take & (data_i < thr_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      low_q <= 1'b0;
    end else if (clear_i) begin
      sum_q <= '0;
      low_q <= 1'b0;
    end else begin
      sum_q <= sum_nxt;
      low_q <= low_nxt;
    end
  end

  assign sum_o = sum_nxt;
  assign low_o = low_nxt;

  // R10: sum never wraps inside a window
  p_sum_no_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (sum_q >= $past(sum_q)));
  // R11: samples outside direct mode leave the accumulator alone
  p_idle_when_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !clear_i) |=> (sum_q == $past(sum_q)));
endmodule

// File: rtl/arc_range_ctrl.sv
module arc_range_ctrl
  import arc_pkg::*;
#(
  parameter int unsigned N_CMP  = 2,
  parameter int unsigned PER_W  = 16,
  parameter int unsigned HOLD_W = 8,
  parameter int unsigned ADC_W  = 16,
  parameter int unsigned RES_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CMP-1:0]  cmp_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [HOLD_W-1:0] holdoff_i,
  input  logic [RES_W-1:0]  max_count_i,
  input  logic [ADC_W-1:0]  return_thr_i,
  input  logic              adc_valid_i,
  input  logic [ADC_W-1:0]  adc_data_i,
  output logic              branch_o,
  output logic              direct_mode_o,
  output logic              res_valid_o,
  output logic              res_mode_o,
  output logic              res_ok_o,
  output logic [RES_W-1:0]  res_value_o
);
  localparam int unsigned PX_W = PER_W + 1;

  arc_mode_e        mode_q, mode_nxt;
  logic [PER_W-1:0] pcnt_q;
  logic             period_end;
  logic             trip, low_seen, settle_q;
  logic [RES_W-1:0] tog_cnt, adc_sum;
  logic             res_valid_q, res_mode_q, res_ok_q;
  logic [RES_W-1:0] res_value_q;

  assign period_end = (PX_W'(pcnt_q) + 1'b1) >= PX_W'(period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pcnt_q <= '0;
    else if (period_end) pcnt_q <= '0;
    else                 pcnt_q <= pcnt_q + 1'b1;
  end

  arc_trip_detect #(.N_CMP(N_CMP)) u_trip (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmp_i  (cmp_i),
    .trip_o (trip)
  );

  arc_toggle_counter #(.CNT_W(RES_W), .HOLD_W(HOLD_W)) u_conv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trip_i    (trip),
    .enable_i  (mode_q == MODE_CONV),
    .holdoff_i (holdoff_i),
    .clear_i   (period_end),
    .branch_o  (branch_o),
    .count_o   (tog_cnt)
  );

  arc_direct_accum #(.ADC_W(ADC_W), .SUM_W(RES_W)) u_direct (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (mode_q == MODE_DIRECT),
    .clear_i  (period_end),
    .valid_i  (adc_valid_i),
    .data_i   (adc_data_i),
    .thr_i    (return_thr_i),
    .sum_o    (adc_sum),
    .low_o    (low_seen)
  );

  // range decision with hysteresis, applied only at window end
  always_comb begin
    mode_nxt = mode_q;
    if (period_end) begin
      if (mode_q == MODE_CONV && tog_cnt >= max_count_i) mode_nxt = MODE_DIRECT;
      if (mode_q == MODE_DIRECT && low_seen)             mode_nxt = MODE_CONV;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= MODE_CONV;
      settle_q    <= 1'b0;
      res_valid_q <= 1'b0;
      res_mode_q  <= 1'b0;
      res_ok_q    <= 1'b0;
      res_value_q <= '0;
    end else begin
      mode_q      <= mode_nxt;
      res_valid_q <= period_end;
      if (period_end) begin
        settle_q    <= (mode_nxt != mode_q);
        res_mode_q  <= mode_q;
        res_ok_q    <= !settle_q;
        res_value_q <= (mode_q == MODE_DIRECT) ? adc_sum : tog_cnt;
      end
    end
  end

  assign direct_mode_o = mode_q;
  assign res_valid_o   = res_valid_q;
  assign res_mode_o    = res_mode_q;
  assign res_ok_o      = res_ok_q;
  assign res_value_o   = res_value_q;

  // R8: mode only moves on a window boundary
  p_mode_at_boundary_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != $past(mode_q)) |-> $past(period_end));
  // R4: a result follows every window end
  p_result_per_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end |=> res_valid_o);
  // R9: a mode change flags the next reported window as unsettled
  p_unsettled_after_switch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && mode_q != res_mode_o) |-> settle_q);
endmodule

// File: tb/arc_range_ctrl_test.sv
module arc_range_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmp = '0;
  logic [15:0] period = 16'd200;
  logic [7:0]  holdoff = 8'd3;
  logic [23:0] max_count = 24'd1000;
  logic [15:0] thr = 16'd100;
  logic        adc_valid = 1'b0;
  logic [15:0] adc_data = '0;
  logic        branch, direct_mode, res_valid, res_mode, res_ok;
  logic [23:0] res_value;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  arc_range_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .cmp_i(cmp), .period_i(period),
    .holdoff_i(holdoff), .max_count_i(max_count), .return_thr_i(thr),
    .adc_valid_i(adc_valid), .adc_data_i(adc_data), .branch_o(branch),
    .direct_mode_o(direct_mode), .res_valid_o(res_valid), .res_mode_o(res_mode),
    .res_ok_o(res_ok), .res_value_o(res_value)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_result();
    do @(negedge clk); while (!res_valid);
  endtask

  task automatic pulses(input int n, input int ch);
    for (int i = 0; i < n; i++) begin
      cmp[ch] = 1'b1;
      repeat (2) @(negedge clk);
      cmp[ch] = 1'b0;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic adc_burst(input int n, input logic [15:0] v);
    adc_data  = v;
    adc_valid = 1'b1;
    repeat (n) @(negedge clk);
    adc_valid = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(branch == 1'b0, "R1 branch", branch, 0);
    chk(direct_mode == 1'b0, "R1 mode", direct_mode, 0);
    chk(res_valid == 1'b0, "R1 valid", res_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(branch == 1'b0 && direct_mode == 1'b0 && res_valid == 1'b0, "R1 after release",
        {branch, direct_mode, res_valid}, 0);
    wait_result();
    chk(res_value == 0 && res_mode == 1'b0, "R4 idle window", res_value, 0);
    chk(res_ok == 1'b1, "R9 first window after reset", res_ok, 1);
  endtask

  task automatic t_period();
    int n = 0;
    do begin @(negedge clk); n++; end while (!res_valid);
    chk(n == 200, "R4 window length", n, 200);
    @(negedge clk);
    chk(res_valid == 1'b0, "R4 single-cycle strobe", res_valid, 0);
  endtask

  task automatic t_count();
    logic b0;
    wait_result();
    b0 = branch;
    for (int i = 0; i < 7; i++) pulses(1, i % 2);
    chk(branch == ~b0, "R2 branch parity after 7 trips", branch, ~b0);
    wait_result();
    chk(res_value == 7, "R4 count both comparators", res_value, 7);
    chk(res_mode == 1'b0, "R8 mode tag converter", res_mode, 0);
  endtask

  task automatic t_level();
    cmp[0] = 1'b1;
    repeat (30) @(negedge clk);
    cmp[0] = 1'b0;
    wait_result();
    chk(res_value == 1, "R2 long level counts once", res_value, 1);
  endtask

  task automatic t_holdoff();
    cmp[0] = 1'b1;
    @(negedge clk);
    cmp[1] = 1'b1;
    repeat (4) @(negedge clk);
    cmp = '0;
    wait_result();
    chk(res_value == 1, "R3 second trip blanked", res_value, 1);
    holdoff = 8'd0;
    cmp[0] = 1'b1;
    @(negedge clk);
    cmp[1] = 1'b1;
    repeat (4) @(negedge clk);
    cmp = '0;
    wait_result();
    chk(res_value == 2, "R3 no blanking with zero holdoff", res_value, 2);
    holdoff = 8'd3;
  endtask

  task automatic t_conv_ignores_adc();
    adc_burst(20, 16'd5);
    wait_result();
    chk(res_value == 0, "R11 samples ignored in converter", res_value, 0);
    chk(direct_mode == 1'b0, "R11 no switch from samples", direct_mode, 0);
  endtask

  task automatic t_to_direct();
    logic b0;
    max_count = 24'd5;
    pulses(5, 0);
    chk(direct_mode == 1'b0, "R8 no mid-window switch", direct_mode, 0);
    wait_result();
    chk(res_value == 5 && res_mode == 1'b0, "R5 full-scale window", res_value, 5);
    chk(direct_mode == 1'b1, "R5 switch to direct", direct_mode, 1);
    b0 = branch;
    adc_burst(10, 16'd1000);
    pulses(3, 1);
    chk(branch == b0, "R6 comparators ignored in direct", branch, b0);
    wait_result();
    chk(res_mode == 1'b1, "R8 mode tag direct", res_mode, 1);
    chk(res_value == 10000, "R6 sample sum", res_value, 10000);
    chk(res_ok == 1'b0, "R9 settling window flagged", res_ok, 0);
    adc_burst(4, 16'd2000);
    wait_result();
    chk(res_value == 8000 && res_ok == 1'b1, "R6 R9 settled direct window", res_value, 8000);
    chk(direct_mode == 1'b1, "R7 stays direct above threshold", direct_mode, 1);
  endtask

  task automatic t_saturate();
    period = 16'd400;
    adc_burst(300, 16'hFFFF);
    wait_result();
    period = 16'd200;
    chk(res_value == 24'hFFFFFF, "R10 sum saturates", res_value, 24'hFFFFFF);
  endtask

  task automatic t_back();
    adc_burst(3, 16'd300);
    adc_burst(1, 16'd50);
    repeat (5) @(negedge clk);
    chk(direct_mode == 1'b1, "R8 return waits for boundary", direct_mode, 1);
    wait_result();
    chk(res_value == 950 && res_mode == 1'b1, "R7 last direct window", res_value, 950);
    chk(direct_mode == 1'b0, "R7 back to converter", direct_mode, 0);
    pulses(2, 0);
    wait_result();
    chk(res_mode == 1'b0 && res_value == 2, "R7 converter resumed", res_value, 2);
    chk(res_ok == 1'b0, "R9 settling after return", res_ok, 0);
  endtask

  initial begin
    t_reset();
    t_period();
    t_count();
    t_level();
    t_holdoff();
    t_conv_ignores_adc();
    t_to_direct();
    t_saturate();
    t_back();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule